// File: doc/BRIEF.md
# Interrupt Distributor Register Bank

This block gathers interrupt lines from the rest of the chip and decides, separately for each processor in a small multiprocessor cluster, which single interrupt that processor should service next. For every source it keeps an enable bit, a trigger mode, an 8-bit priority and, for shared sources, a byte that lists which processors may receive it. Each processor's interface gets a request flag, the winning source number and that source's priority. The processor acknowledges the request with a one-cycle strobe.

Sources 0 to 31 are private to each processor. Sources 0 to 15 are raised by software through a dedicated register. Sources 16 to 31 come from per-processor lines. Enable and pending state for these 32 sources is kept in a separate copy per processor, and the processor number that comes with each register access picks the copy. Sources 32 and up are shared lines. Software programs the block through a single-cycle 32-bit register port. Reads are combinational from the word address and the processor number. Writes take effect at the clock edge.

The register map uses word addresses. Control is at 0x00, the line-count report at 0x01 and the software interrupt register at 0x02. The enable-set view starts at 0x10 and the enable-clear view at 0x20, one word per 32 sources. The trigger configuration starts at 0x30, one word per 16 sources. Priorities start at 0x40 and target bytes at 0x80, one word per 4 sources.

Top module: `irq_dist`

## Requirements
- R1: After reset the control bit, all enable bits and all priority bytes read 0. Sources 16 and up read as level-triggered. No processor sees a request.
- R2: In word 0x10+k (set view) a 1 in bit b enables source 32k+b, and in word 0x20+k (clear view) a 1 disables it. Zero bits change nothing, and both views read the current enable bits.
- R3: Enable and pending state of sources 0 to 31 is kept per processor. An access uses the bank of the processor number on `bus_cpu`, and one processor's enable writes leave every other bank unchanged.
- R4: Source s has a two-bit field at bits 2(s%16)+1 : 2(s%16) of word 0x30+s/16. The upper bit set means rising-edge and clear means level-high, and the lower bit reads 0. Sources 0 to 15 always read 2'b10 and ignore writes.
- R5: The priority of source s is byte s%4 (bits 8(s%4)+7 : 8(s%4)) of word 0x40+s/4, and it reads back as written.
- R6: For a shared source, bit c of byte s%4 of word 0x80+s/4 allows delivery to processor c. For a private source the byte reads as the accessing processor's one-hot bit and ignores writes.
- R7: Control bit 0 enables forwarding. While it is 0, no processor sees a request. The word at 0x01 reads N=(min(count,1020)+31)/32-1 in bits 4:0 (1 for 64 sources).
- R8: A write to 0x02 sets source wdata[3:0] pending in the bank of every processor c whose bit 16+c is set.
- R9: An edge source becomes pending on a rising input and stays pending until its processor acknowledges it. A level source is pending exactly while its input is high, and an acknowledge does not clear it.
- R10: Each processor is given the enabled, pending source targeted to it with the lowest priority value. Ties go to the lowest source number, and the outputs follow a change within two clock cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| bus_en | input | 1 | Register access strobe |
| bus_we | input | 1 | Write when 1, read when 0 |
| bus_cpu | input | CPU_W | Number of the accessing processor |
| bus_addr | input | 8 | Word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr and bus_cpu |
| shared_irq | input | NUM_SRC-32 | Shared lines, bit j is source 32+j |
| private_irq | input | NUM_CPU*16 | Bit 16c+k is source 16+k of processor c |
| cpu_ack | input | NUM_CPU | Per-processor acknowledge of the current request |
| irq_req | output | NUM_CPU | Per-processor request flag |
| irq_id | output | NUM_CPU*ID_W | Winning source number per processor |
| irq_prio | output | NUM_CPU*8 | Priority of the winning source per processor |

## Verification
The hardest state to reach is a software-raised pending bit that sits unseen in one processor's bank. Its enable is off in that bank, while the same source is enabled in another processor's bank that the software write did not target. The stimulus raises a software interrupt toward two processors, only one of which has the source enabled. It then enables the source for the second processor afterwards and expects the stored pending bit to surface. It also checks that a third processor, which has the source enabled but was not listed, never sees it. Ties in priority and ordering between shared and private sources are produced by rewriting one priority word while several level inputs are held high.

// File: rtl/irq_dist_pkg.sv
package irq_dist_pkg;
  localparam int unsigned BUS_W = 32;
  localparam int unsigned PRIV  = 32;
  localparam int unsigned SOFT  = 16;

  localparam logic [7:0] A_CTRL = 8'h00;
  localparam logic [7:0] A_TYPE = 8'h01;
  localparam logic [7:0] A_SGI  = 8'h02;
  localparam logic [7:0] A_ENS  = 8'h10;
  localparam logic [7:0] A_ENC  = 8'h20;
  localparam logic [7:0] A_CFG  = 8'h30;
  localparam logic [7:0] A_PRI  = 8'h40;
  localparam logic [7:0] A_TGT  = 8'h80;

  // line-count report: lines capped at 1020, reported as words of 32 minus one
  function automatic logic [4:0] type_field(int unsigned nsrc);
    int unsigned lines;
    lines = (nsrc > 1020) ? 1020 : nsrc;
    return 5'((lines + 31) / 32 - 1);
  endfunction

  function automatic logic [7:0] en_addr(logic [7:0] base, int s);
    return base + 8'(s / 32);
  endfunction

  function automatic logic [7:0] cfg_addr(int s);
    return A_CFG + 8'(s / 16);
  endfunction

  function automatic int cfg_bit(int s);
    return 2 * (s % 16) + 1;
  endfunction

  function automatic logic [7:0] byte_addr(logic [7:0] base, int s);
    return base + 8'(s / 4);
  endfunction

  function automatic int lane_lsb(int s);
    return 8 * (s % 4);
  endfunction
endpackage

// File: rtl/irq_dist_regs.sv
module irq_dist_regs
  import irq_dist_pkg::*;
#(
  parameter int unsigned NUM_SRC = 64,
  parameter int unsigned NUM_CPU = 8,
  localparam int unsigned CPU_W  = (NUM_CPU > 1) ? $clog2(NUM_CPU) : 1,
  localparam int unsigned NUM_SH = NUM_SRC - PRIV
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    bus_en,
  input  logic                    bus_we,
  input  logic [CPU_W-1:0]        bus_cpu,
  input  logic [7:0]              bus_addr,
  input  logic [BUS_W-1:0]        bus_wdata,
  output logic [BUS_W-1:0]        bus_rdata,
  output logic                    dist_en,
  output logic [NUM_CPU*PRIV-1:0] en_pv,
  output logic [NUM_SH-1:0]       en_sh,
  output logic [NUM_SRC-1:16]     edge_cfg,
  output logic [NUM_SRC*8-1:0]    prio_flat,
  output logic [NUM_SH*8-1:0]     tgt_flat,
  output logic                    sgi_fire,
  output logic [3:0]              sgi_id,
  output logic [7:0]              sgi_cpus
);
  logic       wr;
  logic [7:0] self_bit;

  assign wr       = bus_en && bus_we;
  assign self_bit = 8'(1) << bus_cpu;
  assign sgi_fire = wr && (bus_addr == A_SGI);
  assign sgi_id   = bus_wdata[3:0];
  assign sgi_cpus = bus_wdata[23:16];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dist_en   <= 1'b0;
      en_pv     <= '0;
      en_sh     <= '0;
      edge_cfg  <= '0;
      prio_flat <= '0;
      tgt_flat  <= '0;
    end else if (wr) begin
      if (bus_addr == A_CTRL) dist_en <= bus_wdata[0];
      for (int s = 0; s < PRIV; s++) begin
        if (bus_addr == A_ENS && bus_wdata[s]) en_pv[{bus_cpu, 5'(s)}] <= 1'b1;
        if (bus_addr == A_ENC && bus_wdata[s]) en_pv[{bus_cpu, 5'(s)}] <= 1'b0;
      end
      for (int j = 0; j < NUM_SH; j++) begin
        if (bus_addr == en_addr(A_ENS, j + PRIV) && bus_wdata[j % 32]) en_sh[j] <= 1'b1;
        if (bus_addr == en_addr(A_ENC, j + PRIV) && bus_wdata[j % 32]) en_sh[j] <= 1'b0;
        if (bus_addr == byte_addr(A_TGT, j + PRIV))
          tgt_flat[j*8 +: 8] <= bus_wdata[lane_lsb(j + PRIV) +: 8];
      end
      for (int s = SOFT; s < NUM_SRC; s++) begin
        if (bus_addr == cfg_addr(s)) edge_cfg[s] <= bus_wdata[cfg_bit(s)];
      end
      for (int s = 0; s < NUM_SRC; s++) begin
        if (bus_addr == byte_addr(A_PRI, s)) prio_flat[s*8 +: 8] <= bus_wdata[lane_lsb(s) +: 8];
      end
    end
  end

  always_comb begin
    bus_rdata = '0;
    if (bus_addr == A_CTRL) bus_rdata[0] = dist_en;
    if (bus_addr == A_TYPE) bus_rdata[4:0] = type_field(NUM_SRC);
    for (int s = 0; s < PRIV; s++) begin
      if (bus_addr == A_ENS || bus_addr == A_ENC) bus_rdata[s] = en_pv[{bus_cpu, 5'(s)}];
      if (bus_addr == byte_addr(A_TGT, s)) bus_rdata[lane_lsb(s) +: 8] = self_bit;
    end
    for (int j = 0; j < NUM_SH; j++) begin
      if (bus_addr == en_addr(A_ENS, j + PRIV) || bus_addr == en_addr(A_ENC, j + PRIV))
        bus_rdata[j % 32] = en_sh[j];
      if (bus_addr == byte_addr(A_TGT, j + PRIV))
        bus_rdata[lane_lsb(j + PRIV) +: 8] = tgt_flat[j*8 +: 8];
    end
    for (int s = 0; s < SOFT; s++) begin
      if (bus_addr == A_CFG) bus_rdata[cfg_bit(s)] = 1'b1;
    end
    for (int s = SOFT; s < NUM_SRC; s++) begin
      if (bus_addr == cfg_addr(s)) bus_rdata[cfg_bit(s)] = edge_cfg[s];
    end
    for (int s = 0; s < NUM_SRC; s++) begin
      if (bus_addr == byte_addr(A_PRI, s)) bus_rdata[lane_lsb(s) +: 8] = prio_flat[s*8 +: 8];
    end
  end

  // R2: set view turns on every written 1 of the first shared word
  p_set_view_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && bus_addr == A_ENS + 8'd1) |=> ((en_sh[31:0] & $past(bus_wdata)) == $past(bus_wdata)));
  // R2: clear view turns off every written 1
  p_clr_view_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && bus_addr == A_ENC + 8'd1) |=> ((en_sh[31:0] & $past(bus_wdata)) == '0));
endmodule

// File: rtl/irq_dist_pend.sv
module irq_dist_pend
  import irq_dist_pkg::*;
#(
  parameter int unsigned NUM_SRC = 64,
  parameter int unsigned NUM_CPU = 8,
  localparam int unsigned ID_W   = $clog2(NUM_SRC),
  localparam int unsigned NUM_SH = NUM_SRC - PRIV
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [NUM_SH-1:0]       shared_irq,
  input  logic [NUM_CPU*16-1:0]   private_irq,
  input  logic [NUM_SRC-1:16]     edge_cfg,
  input  logic                    sgi_fire,
  input  logic [3:0]              sgi_id,
  input  logic [7:0]              sgi_cpus,
  input  logic [NUM_CPU-1:0]      ack_fire,
  input  logic [NUM_CPU*ID_W-1:0] ack_id,
  output logic [NUM_SH-1:0]       pend_sh,
  output logic [NUM_CPU*PRIV-1:0] pend_pv
);
  logic [NUM_SH-1:0]       sh_q, sh_rise, clr_sh;
  logic [NUM_CPU*16-1:0]   pv_q, pv_rise;
  logic [NUM_CPU*PRIV-1:0] clr_pv, sgi_set;

  assign sh_rise = shared_irq & ~sh_q;
  assign pv_rise = private_irq & ~pv_q;

  always_comb begin
    clr_sh  = '0;
    clr_pv  = '0;
    sgi_set = '0;
    for (int c = 0; c < NUM_CPU; c++) begin
      for (int j = 0; j < NUM_SH; j++)
        if (ack_fire[c] && ack_id[c*ID_W +: ID_W] == ID_W'(j + PRIV)) clr_sh[j] = 1'b1;
      for (int s = 0; s < PRIV; s++)
        clr_pv[c*PRIV + s] = ack_fire[c] && (ack_id[c*ID_W +: ID_W] == ID_W'(s));
      for (int s = 0; s < SOFT; s++)
        sgi_set[c*PRIV + s] = sgi_fire && sgi_cpus[c] && (sgi_id == 4'(s));
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q    <= '0;
      pv_q    <= '0;
      pend_sh <= '0;
      pend_pv <= '0;
    end else begin
      sh_q <= shared_irq;
      pv_q <= private_irq;
      for (int j = 0; j < NUM_SH; j++) begin
        if (edge_cfg[j + PRIV]) pend_sh[j] <= (pend_sh[j] && !clr_sh[j]) || sh_rise[j];
        else                    pend_sh[j] <= shared_irq[j];
      end
      for (int c = 0; c < NUM_CPU; c++) begin
        for (int s = 0; s < SOFT; s++)
          pend_pv[c*PRIV + s] <= (pend_pv[c*PRIV + s] && !clr_pv[c*PRIV + s]) || sgi_set[c*PRIV + s];
        for (int k = 0; k < 16; k++) begin
          if (edge_cfg[SOFT + k])
            pend_pv[c*PRIV + SOFT + k] <= (pend_pv[c*PRIV + SOFT + k] && !clr_pv[c*PRIV + SOFT + k])
                                          || pv_rise[c*16 + k];
          else
            pend_pv[c*PRIV + SOFT + k] <= private_irq[c*16 + k];
        end
      end
    end
  end

  // R9: a level-configured shared source mirrors its input one cycle later
  p_level_track_r9: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (((pend_sh ^ $past(shared_irq)) & ~$past(edge_cfg[NUM_SRC-1:PRIV])) == '0));

  for (genvar c = 0; c < NUM_CPU; c++) begin : g_sgi_chk
    // R8: a listed processor holds the software source pending after the write
    p_sgi_sets_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (sgi_fire && sgi_cpus[c]) |=> pend_pv[c*PRIV + int'($past(sgi_id))]);
  end
endmodule

// File: rtl/irq_dist_arb.sv
module irq_dist_arb #(
  parameter int unsigned NUM_SRC = 64,
  localparam int unsigned ID_W   = $clog2(NUM_SRC)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 gate,
  input  logic [NUM_SRC-1:0]   pend,
  input  logic [NUM_SRC-1:0]   en,
  input  logic [NUM_SRC-1:0]   tgt,
  input  logic [NUM_SRC*8-1:0] prio_flat,
  output logic                 win_valid,
  output logic [ID_W-1:0]      win_id,
  output logic [7:0]           win_prio
);
  logic [NUM_SRC-1:0] cand;

  assign cand = pend & en & tgt & {NUM_SRC{gate}};

  // strict less-than while scanning upward keeps the lowest number on ties
  always_comb begin
    win_valid = 1'b0;
    win_id    = '0;
    win_prio  = 8'hFF;
    for (int s = 0; s < NUM_SRC; s++) begin
      if (cand[s] && (!win_valid || prio_flat[s*8 +: 8] < win_prio)) begin
        win_valid = 1'b1;
        win_id    = ID_W'(s);
        win_prio  = prio_flat[s*8 +: 8];
      end
    end
  end

  // R10: a winner is always a live candidate carrying its own priority
  p_win_is_cand_r10: assert property (@(posedge clk) disable iff (!rst_n)
    win_valid |-> (cand[win_id] && win_prio == prio_flat[win_id*8 +: 8]));
  // R10: with any candidate present, a winner is produced
  p_win_exists_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (cand != '0) |-> win_valid);
endmodule

// File: rtl/irq_dist.sv
module irq_dist
  import irq_dist_pkg::*;
#(
  parameter int unsigned NUM_SRC = 64,
  parameter int unsigned NUM_CPU = 8,
  localparam int unsigned CPU_W  = (NUM_CPU > 1) ? $clog2(NUM_CPU) : 1,
  localparam int unsigned ID_W   = $clog2(NUM_SRC),
  localparam int unsigned NUM_SH = NUM_SRC - PRIV
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    bus_en,
  input  logic                    bus_we,
  input  logic [CPU_W-1:0]        bus_cpu,
  input  logic [7:0]              bus_addr,
  input  logic [31:0]             bus_wdata,
  output logic [31:0]             bus_rdata,
  input  logic [NUM_SH-1:0]       shared_irq,
  input  logic [NUM_CPU*16-1:0]   private_irq,
  input  logic [NUM_CPU-1:0]      cpu_ack,
  output logic [NUM_CPU-1:0]      irq_req,
  output logic [NUM_CPU*ID_W-1:0] irq_id,
  output logic [NUM_CPU*8-1:0]    irq_prio
);
  logic                    dist_en, sgi_fire;
  logic [3:0]              sgi_id;
  logic [7:0]              sgi_cpus;
  logic [NUM_CPU*PRIV-1:0] en_pv, pend_pv;
  logic [NUM_SH-1:0]       en_sh, pend_sh;
  logic [NUM_SRC-1:16]     edge_cfg;
  logic [NUM_SRC*8-1:0]    prio_flat;
  logic [NUM_SH*8-1:0]     tgt_flat;
  logic [NUM_CPU-1:0]      ack_fire;

  assign ack_fire = cpu_ack & irq_req;

  irq_dist_regs #(.NUM_SRC(NUM_SRC), .NUM_CPU(NUM_CPU)) u_regs (
    .clk(clk), .rst_n(rst_n), .bus_en(bus_en), .bus_we(bus_we), .bus_cpu(bus_cpu),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .dist_en(dist_en), .en_pv(en_pv), .en_sh(en_sh), .edge_cfg(edge_cfg),
    .prio_flat(prio_flat), .tgt_flat(tgt_flat),
    .sgi_fire(sgi_fire), .sgi_id(sgi_id), .sgi_cpus(sgi_cpus)
  );

  irq_dist_pend #(.NUM_SRC(NUM_SRC), .NUM_CPU(NUM_CPU)) u_pend (
    .clk(clk), .rst_n(rst_n), .shared_irq(shared_irq), .private_irq(private_irq),
    .edge_cfg(edge_cfg), .sgi_fire(sgi_fire), .sgi_id(sgi_id), .sgi_cpus(sgi_cpus),
    .ack_fire(ack_fire), .ack_id(irq_id), .pend_sh(pend_sh), .pend_pv(pend_pv)
  );

  for (genvar c = 0; c < NUM_CPU; c++) begin : g_cpu
    logic [NUM_SRC-1:0] pend_c, en_c, tgt_c;
    logic               win_valid;
    logic [ID_W-1:0]    win_id;
    logic [7:0]         win_prio;

    always_comb begin
      pend_c = {pend_sh, pend_pv[c*PRIV +: PRIV]};
      en_c   = {en_sh, en_pv[c*PRIV +: PRIV]};
      tgt_c  = '0;
      tgt_c[PRIV-1:0] = '1;
      for (int j = 0; j < NUM_SH; j++) tgt_c[j + PRIV] = tgt_flat[j*8 + c];
    end

    irq_dist_arb #(.NUM_SRC(NUM_SRC)) u_arb (
      .clk(clk), .rst_n(rst_n), .gate(dist_en), .pend(pend_c), .en(en_c), .tgt(tgt_c),
      .prio_flat(prio_flat), .win_valid(win_valid), .win_id(win_id), .win_prio(win_prio)
    );

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        irq_req[c]               <= 1'b0;
        irq_id[c*ID_W +: ID_W]   <= '0;
        irq_prio[c*8 +: 8]       <= '0;
      end else begin
        irq_req[c]               <= win_valid;
        irq_id[c*ID_W +: ID_W]   <= win_id;
        irq_prio[c*8 +: 8]       <= win_prio;
      end
    end
  end

  // R7: with forwarding off, no processor sees a request on the next cycle
  p_gate_off_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !dist_en |=> (irq_req == '0));
endmodule

// File: tb/irq_dist_bench.sv
module irq_dist_bench;
  localparam int NUM_SRC = 64;
  localparam int NUM_CPU = 8;
  localparam int ID_W    = 6;

  logic                  clk = 1'b0;
  logic                  rst_n = 1'b0;
  logic                  bus_en = 1'b0, bus_we = 1'b0;
  logic [2:0]            bus_cpu = '0;
  logic [7:0]            bus_addr = '0;
  logic [31:0]           bus_wdata = '0;
  logic [31:0]           bus_rdata;
  logic [NUM_SRC-33:0]   shared_irq = '0;
  logic [NUM_CPU*16-1:0] private_irq = '0;
  logic [NUM_CPU-1:0]    cpu_ack = '0;
  logic [NUM_CPU-1:0]    irq_req;
  logic [NUM_CPU*ID_W-1:0] irq_id;
  logic [NUM_CPU*8-1:0]  irq_prio;

  int n_chk = 0, n_fail = 0;
  bit finished = 0;

  // scoreboard queues: kind 0 = register read, kind 1 = processor request
  int          kind_q[$];
  int          cpu_q[$];
  logic [31:0] exp_q[$];
  string       tag_q[$];
  event        mon_ev;

  always #10 clk = ~clk;

  irq_dist u_irq_dist (
    .clk(clk), .rst_n(rst_n), .bus_en(bus_en), .bus_we(bus_we), .bus_cpu(bus_cpu),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .shared_irq(shared_irq), .private_irq(private_irq), .cpu_ack(cpu_ack),
    .irq_req(irq_req), .irq_id(irq_id), .irq_prio(irq_prio)
  );

  // request encoding used by the scoreboard: bit 8 = request, bits 5:0 = source
  function automatic logic [31:0] req_word(bit req, int id);
    return req ? (32'h100 | 32'(id)) : 32'h0;
  endfunction

  initial begin : monitor
    forever begin
      @(mon_ev);
      while (kind_q.size() > 0) begin
        automatic int          k = kind_q.pop_front();
        automatic int          c = cpu_q.pop_front();
        automatic logic [31:0] e = exp_q.pop_front();
        automatic string       t = tag_q.pop_front();
        automatic logic [31:0] a;
        if (k == 0) a = bus_rdata;
        else        a = req_word(irq_req[c], int'(irq_id[c*ID_W +: ID_W]));
        n_chk++;
        if (a !== e) begin
          n_fail++;
          $display("FAIL %s: actual %h expected %h", t, a, e);
        end
      end
    end
  end

  task automatic push(int k, int c, logic [31:0] e, string t);
    kind_q.push_back(k); cpu_q.push_back(c); exp_q.push_back(e); tag_q.push_back(t);
    -> mon_ev;
    #1;
  endtask

  task automatic wr(int cpu, logic [7:0] addr, logic [31:0] data);
    @(negedge clk);
    bus_cpu = 3'(cpu); bus_addr = addr; bus_wdata = data; bus_en = 1'b1; bus_we = 1'b1;
    @(negedge clk);
    bus_en = 1'b0; bus_we = 1'b0;
  endtask

  task automatic rd_chk(int cpu, logic [7:0] addr, logic [31:0] e, string t);
    @(negedge clk);
    bus_cpu = 3'(cpu); bus_addr = addr;
    #2;
    push(0, cpu, e, t);
  endtask

  task automatic settle();
    repeat (3) @(negedge clk);
  endtask

  task automatic irq_chk(int cpu, bit req, int id, string t);
    @(negedge clk);
    #2;
    push(1, cpu, req_word(req, id), t);
  endtask

  task automatic ack(int cpu);
    @(negedge clk);
    cpu_ack[cpu] = 1'b1;
    @(negedge clk);
    cpu_ack[cpu] = 1'b0;
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual hung expected done");
      finish_run();
    end
  end

  initial begin : driver
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    rd_chk(0, 8'h00, 32'h0, "R1 control after reset");
    rd_chk(0, 8'h10, 32'h0, "R1 private enables after reset");
    rd_chk(0, 8'h11, 32'h0, "R1 shared enables after reset");
    rd_chk(0, 8'h30, 32'hAAAAAAAA, "R1 R4 software sources fixed edge");
    rd_chk(0, 8'h32, 32'h0, "R1 shared level after reset");
    rd_chk(0, 8'h48, 32'h0, "R1 priority after reset");
    irq_chk(0, 0, 0, "R1 no request cpu0");
    irq_chk(7, 0, 0, "R1 no request cpu7");
    // R7 line count
    rd_chk(0, 8'h01, 32'h1, "R7 type register");
    // R2 set/clear views
    wr(0, 8'h11, 32'h000000F0);
    rd_chk(0, 8'h21, 32'h000000F0, "R2 clear view reads enables");
    wr(0, 8'h21, 32'h00000030);
    rd_chk(0, 8'h11, 32'h000000C0, "R2 clear view removes ones");
    wr(0, 8'h11, 32'h0);
    rd_chk(0, 8'h11, 32'h000000C0, "R2 zero bits ignored");
    // R3 banking
    wr(1, 8'h10, 32'h000000FF);
    rd_chk(1, 8'h10, 32'h000000FF, "R3 own bank");
    rd_chk(2, 8'h10, 32'h0, "R3 other bank untouched");
    wr(2, 8'h20, 32'hFFFFFFFF);
    rd_chk(1, 8'h10, 32'h000000FF, "R3 clear in another bank");
    // R4 configuration
    wr(0, 8'h30, 32'h0);
    rd_chk(0, 8'h30, 32'hAAAAAAAA, "R4 software source writes ignored");
    wr(0, 8'h31, 32'hFFFFFFFF);
    rd_chk(0, 8'h31, 32'hAAAAAAAA, "R4 low bit of pair reads zero");
    wr(0, 8'h31, 32'h0);
    rd_chk(0, 8'h31, 32'h0, "R4 back to level");
    wr(0, 8'h32, 32'h00000002);
    rd_chk(0, 8'h32, 32'h00000002, "R4 source 32 edge");
    // R5 priority
    wr(0, 8'h48, 32'h44332211);
    rd_chk(0, 8'h48, 32'h44332211, "R5 priority readback");
    wr(0, 8'h41, 32'h00001000);
    // R6 targets
    wr(0, 8'h88, 32'h0F0F0301);
    rd_chk(0, 8'h88, 32'h0F0F0301, "R6 shared target readback");
    rd_chk(3, 8'h80, 32'h08080808, "R6 private target is self cpu3");
    wr(0, 8'h80, 32'hFFFFFFFF);
    rd_chk(0, 8'h80, 32'h01010101, "R6 private target ignores writes");
    // interrupt flow
    wr(0, 8'h21, 32'hFFFFFFFF);
    wr(0, 8'h00, 32'h1);
    rd_chk(0, 8'h00, 32'h1, "R7 control readback");
    wr(0, 8'h11, 32'h00000002);
    shared_irq[1] = 1'b1;
    settle();
    irq_chk(0, 1, 33, "R9 level source to cpu0");
    irq_chk(1, 1, 33, "R6 level source to cpu1");
    irq_chk(2, 0, 0, "R6 cpu2 not targeted");
    ack(0);
    settle();
    irq_chk(0, 1, 33, "R9 ack does not clear level");
    shared_irq[1] = 1'b0;
    settle();
    irq_chk(0, 0, 0, "R9 level drops with input");
    wr(0, 8'h11, 32'h00000001);
    @(negedge clk); shared_irq[0] = 1'b1;
    @(negedge clk); shared_irq[0] = 1'b0;
    settle();
    irq_chk(0, 1, 32, "R9 edge latched after pulse");
    ack(0);
    settle();
    irq_chk(0, 0, 0, "R9 edge cleared by ack");
    // R10 arbitration
    wr(0, 8'h11, 32'h0000000C);
    wr(0, 8'h48, 32'h30302211);
    shared_irq[3:2] = 2'b11;
    settle();
    irq_chk(0, 1, 34, "R10 tie goes to lowest id");
    wr(0, 8'h48, 32'h20302211);
    settle();
    irq_chk(2, 1, 35, "R10 lower value wins");
    shared_irq[1] = 1'b1;
    wr(0, 8'h11, 32'h00000002);
    settle();
    irq_chk(0, 1, 35, "R10 0x20 beats 0x22");
    wr(0, 8'h48, 32'h40302211);
    settle();
    irq_chk(0, 1, 33, "R10 reorder after priority write");
    irq_chk(2, 1, 34, "R10 R6 cpu2 ignores untargeted 33");
    wr(0, 8'h21, 32'h00000002);
    settle();
    irq_chk(0, 1, 34, "R2 disabled source drops out");
    wr(0, 8'h00, 32'h0);
    settle();
    irq_chk(0, 0, 0, "R7 forwarding off cpu0");
    irq_chk(2, 0, 0, "R7 forwarding off cpu2");
    wr(0, 8'h00, 32'h1);
    shared_irq[3:1] = 3'b000;
    settle();
    irq_chk(0, 0, 0, "R9 all levels low");
    // R8 software interrupts
    wr(3, 8'h10, 32'h00000020);
    wr(0, 8'h02, 32'h000C0005);
    settle();
    irq_chk(3, 1, 5, "R8 listed cpu3 receives");
    irq_chk(2, 0, 0, "R8 cpu2 pending but disabled");
    irq_chk(1, 0, 0, "R8 R3 unlisted cpu1 stays quiet");
    wr(2, 8'h10, 32'h00000020);
    settle();
    irq_chk(2, 1, 5, "R8 R3 banked pending surfaces on enable");
    ack(3);
    settle();
    irq_chk(3, 0, 0, "R8 ack clears cpu3 bank");
    irq_chk(2, 1, 5, "R3 cpu2 bank unaffected by cpu3 ack");
    ack(2);
    settle();
    irq_chk(2, 0, 0, "R8 ack clears cpu2 bank");
    // R3 private line
    wr(1, 8'h10, 32'h00010000);
    wr(0, 8'h10, 32'h00010000);
    private_irq[16] = 1'b1;
    settle();
    irq_chk(1, 1, 16, "R3 private line on cpu1");
    irq_chk(0, 0, 0, "R3 cpu0 sees no cpu1 private line");
    private_irq[16] = 1'b0;
    settle();
    irq_chk(1, 0, 0, "R9 private level released");
    finished = 1;
    finish_run();
  end
endmodule